// File: doc/BRIEF.md
# Converter Control-Port Decoder

This block models the digital side of a 12-bit successive-approximation converter as seen by a host bus. Five control inputs drive it: chip enable, active-low chip select, read/convert, a data-mode select and a byte address. The block decodes them into conversion starts and bus reads. It raises a busy status while a conversion runs and presents the stored result on a 12-bit data bus.

A conversion starts on the clock where the start condition becomes true. The start condition is chip enable high, chip select low and read/convert low. Any of the three lines can complete it: chip enable rising, chip select falling or read/convert falling. The byte address sampled at that moment chooses the length of the conversion. A short conversion keeps only the top eight bits. The conversion itself is a fixed count of clock cycles. At its end, the result is taken from the `sample_i` port.

A read returns either all twelve bits at once or one byte at a time, with the byte left-justified. The three-state bus is modelled as a value plus an enable. The pad ring turns `bus_oe_o` into the high-impedance control.

Top module: `adc_ctrl_port`

## Requirements
- R1: A conversion starts when chip enable is 1, chip select is 0 and read/convert is 0, and one of these occurred on that sampled clock: chip enable went 0→1, chip select went 1→0, or read/convert went 1→0. Edges are found by comparing each input with its value on the previous clock. After reset, the previous values count as enable 0, select 1 and read/convert 1.
- R2: If the start condition simply stays true with no completing edge, for example after a conversion has ended, no new conversion starts.
- R3: If byte address is 1 at the start, `busy_o` stays high for CYC_SHORT clocks (default 10). If it is 0, `busy_o` stays high for CYC_FULL clocks (default 14).
- R4: `busy_o` rises on the clock edge that samples the start and then stays high without a break until the conversion ends.
- R5: A start condition that arises while `busy_o` is high is ignored, and it does not change the length of the conversion in progress.
- R6: `bus_oe_o` is 1 exactly when chip enable is 1, chip select is 0, read/convert is 1 and `busy_o` is 0. Whenever `bus_oe_o` is 0, `data_o` is all zeros.
- R7: During a read with the data-mode select at 1, `data_o` carries the whole 12-bit result.
- R8: During a read with the data-mode select at 0, `data_o[3:0]` is 0. With byte address 0, `data_o[11:4]` carries result bits 11..4. With byte address 1, `data_o[11:4]` carries result bits 3..0 followed by four 0 bits.
- R9: The result is captured from `sample_i` on the edge where busy ends. A full conversion stores all 12 bits. A short conversion stores `sample_i[11:4]` in the upper bits and zeros in bits 3..0.
- R10: After reset, `busy_o` is 0 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en_i | input | 1 | Chip enable, active high |
| chip_sel_n_i | input | 1 | Chip select, active low |
| rd_conv_i | input | 1 | 1 = read, 0 = convert |
| wide_rd_i | input | 1 | 1 = 12-bit read, 0 = byte read |
| byte_addr_i | input | 1 | Length select at start, byte select at read |
| sample_i | input | 12 | Digital value the conversion returns |
| busy_o | output | 1 | High while a conversion runs |
| bus_oe_o | output | 1 | Data bus drive enable |
| data_o | output | 12 | Data bus value, zero when not driven |

## Verification
Conversions are started in three ways: through read/convert falling, through chip enable rising and through chip select falling. Mixing these paths separates correct edge detection from a decoder that only watches one line. Short and full starts alternate, and the measured busy length must tell the two cycle counts apart. Line toggles during busy, and a condition held after busy ends, must both leave the count unchanged.

Reads are tried in wide mode and with both byte addresses, using samples whose nibbles all differ. This exposes any swapped nibble or missing zero fill. Reads with enable low, select high or a conversion running must keep the bus off.

// File: rtl/adc_ctrl_pkg.sv
// Shared types for the converter control-port decoder.
// Assumes a single clock domain; nothing here holds state.
package adc_ctrl_pkg;

    // Which view of the result a read puts on the bus
    typedef enum logic [1:0] {
        RD_OFF  = 2'd0,
        RD_WIDE = 2'd1,
        RD_HIGH = 2'd2,
        RD_LOW  = 2'd3
    } rd_view_e;

    // Pick the bus view from the read-side control inputs
    function automatic rd_view_e pick_view(input logic enable, input logic wide,
                                           input logic low_byte);
        if (!enable)      return RD_OFF;
        else if (wide)    return RD_WIDE;
        else if (low_byte) return RD_LOW;
        else              return RD_HIGH;
    endfunction

endpackage

// File: rtl/adc_edge_detect.sv
// Registers the three start-related control lines and flags the clock where
// the start condition (enable high, select low, convert low) is completed by
// an edge on any one of them. Assumes inputs are already synchronous to clk.
module adc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sel_n_i,
    input  logic rdc_i,
    output logic start_o
);
    logic en_q, sel_n_q, rdc_q;
    logic cond, en_rise, sel_fall, rdc_fall;

    // Hold last-clock values; reset to the inactive levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            sel_n_q <= 1'b1;
            rdc_q   <= 1'b1;
        end else begin
            en_q    <= en_i;
            sel_n_q <= sel_n_i;
            rdc_q   <= rdc_i;
        end
    end

    // Detect the completing edge of the start condition
    always_comb begin
        cond     = en_i & ~sel_n_i & ~rdc_i;
        en_rise  = en_i & ~en_q;
        sel_fall = ~sel_n_i & sel_n_q;
        rdc_fall = ~rdc_i & rdc_q;
        start_o  = cond & (en_rise | sel_fall | rdc_fall);
    end

    // R2
    no_repeat_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

endmodule

// File: rtl/adc_conv_timer.sv
// Runs one conversion at a time: latches the length select on start, counts
// the busy window, and stores the sample (truncated for short runs) when it
// ends. Assumes CYC_SHORT and CYC_FULL are at least 1.
module adc_conv_timer #(
    parameter int DATA_W    = 12,
    parameter int BYTE_W    = 8,
    parameter int CYC_FULL  = 14,
    parameter int CYC_SHORT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              short_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int CNT_W  = $clog2(CYC_FULL + 1);
    localparam int LOW_W  = DATA_W - BYTE_W;
    localparam logic [CNT_W-1:0] LOAD_FULL  = CNT_W'(CYC_FULL - 1);
    localparam logic [CNT_W-1:0] LOAD_SHORT = CNT_W'(CYC_SHORT - 1);

    logic              busy_q, short_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] result_q;
    logic [DATA_W-1:0] captured;

    // Shape the stored value according to the latched length
    always_comb begin
        if (short_q) captured = {sample_i[DATA_W-1 -: BYTE_W], {LOW_W{1'b0}}};
        else         captured = sample_i;
    end

    // Busy window counter, length latch and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            short_q  <= 1'b0;
            cnt_q    <= '0;
            result_q <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q   <= 1'b0;
                result_q <= captured;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (start_i) begin
            busy_q  <= 1'b1;
            short_q <= short_i;
            cnt_q   <= short_i ? LOAD_SHORT : LOAD_FULL;
        end
    end

    assign busy_o   = busy_q;
    assign result_o = result_q;

    // R4
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_q) |=> (busy_q &&
            cnt_q == ($past(short_i) ? LOAD_SHORT : LOAD_FULL)));

    // R5
    ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

    // R9
    short_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == '0 && short_q) |=> (result_q[LOW_W-1:0] == '0));

endmodule

// File: rtl/adc_read_mux.sv
// Decodes the read side: enables the bus only for a read while idle and
// selects the wide word, the high byte or the left-justified low byte.
// Assumes BYTE_W >= DATA_W - BYTE_W so the low nibble fits in a byte lane.
module adc_read_mux
    import adc_ctrl_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              sel_n_i,
    input  logic              rdc_i,
    input  logic              wide_i,
    input  logic              byte_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              oe_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int LOW_W = DATA_W - BYTE_W;
    localparam int PAD_W = BYTE_W - LOW_W;

    rd_view_e view;
    logic [BYTE_W-1:0] low_lane;

    // Read enable and view selection
    always_comb begin
        oe_o     = en_i & ~sel_n_i & rdc_i & ~busy_i;
        view     = pick_view(oe_o, wide_i, byte_i);
        low_lane = {result_i[LOW_W-1:0], {PAD_W{1'b0}}};
    end

    // Route the selected view onto the bus lanes
    always_comb begin
        unique case (view)
            RD_WIDE: data_o = result_i;
            RD_HIGH: data_o = {result_i[DATA_W-1 -: BYTE_W], {LOW_W{1'b0}}};
            RD_LOW:  data_o = {low_lane, {LOW_W{1'b0}}};
            default: data_o = '0;
        endcase
    end

    // R6
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_o |-> !busy_i);

    // R8
    byte_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_o && !wide_i) |-> (data_o[LOW_W-1:0] == '0));

endmodule

// File: rtl/adc_ctrl_port.sv
// Top of the converter control-port decoder. Wires edge detection, the
// conversion timer and the read multiplexer. The three-state bus is given as
// a value plus one enable; the pad ring applies high impedance.
module adc_ctrl_port #(
    parameter int DATA_W    = 12,
    parameter int BYTE_W    = 8,
    parameter int CYC_FULL  = 14,
    parameter int CYC_SHORT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en_i,
    input  logic              chip_sel_n_i,
    input  logic              rd_conv_i,
    input  logic              wide_rd_i,
    input  logic              byte_addr_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic              busy_o,
    output logic              bus_oe_o,
    output logic [DATA_W-1:0] data_o
);
    logic              start;
    logic [DATA_W-1:0] result;

    adc_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (chip_en_i),
        .sel_n_i (chip_sel_n_i),
        .rdc_i   (rd_conv_i),
        .start_o (start)
    );

    adc_conv_timer #(
        .DATA_W   (DATA_W),
        .BYTE_W   (BYTE_W),
        .CYC_FULL (CYC_FULL),
        .CYC_SHORT(CYC_SHORT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .short_i  (byte_addr_i),
        .sample_i (sample_i),
        .busy_o   (busy_o),
        .result_o (result)
    );

    adc_read_mux #(
        .DATA_W(DATA_W),
        .BYTE_W(BYTE_W)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (chip_en_i),
        .sel_n_i  (chip_sel_n_i),
        .rdc_i    (rd_conv_i),
        .wide_i   (wide_rd_i),
        .byte_i   (byte_addr_i),
        .busy_i   (busy_o),
        .result_i (result),
        .oe_o     (bus_oe_o),
        .data_o   (data_o)
    );

endmodule

// File: tb/tb_adc_ctrl_port.sv
// Bench: behavioural reference model compared at every falling edge,
// plus directed checks for lengths, ignored starts and reset state.
module tb_adc_ctrl_port;
    localparam int CLK_PERIOD = 10;
    localparam int CF = 14;
    localparam int CS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, sel_n = 1'b1, rdc = 1'b1, wide = 1'b1, baddr = 1'b0;
    logic [11:0] sample = 12'h000;
    logic busy, oe;
    logic [11:0] data;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int  m_left = 0;
    bit  m_short = 0;
    bit  p_en = 0, p_seln = 1, p_rdc = 1;
    logic [11:0] m_res = 12'h000;

    adc_ctrl_port dut (
        .clk(clk), .rst_n(rst_n), .chip_en_i(en), .chip_sel_n_i(sel_n),
        .rd_conv_i(rdc), .wide_rd_i(wide), .byte_addr_i(baddr),
        .sample_i(sample), .busy_o(busy), .bus_oe_o(oe), .data_o(data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Model update at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_left = 0; m_short = 0; m_res = 12'h000;
            p_en = 0; p_seln = 1; p_rdc = 1;
        end else begin
            bit trig;
            trig = en && !sel_n && !rdc &&
                   ((en && !p_en) || (!sel_n && p_seln) || (!rdc && p_rdc));
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0)
                    m_res = m_short ? {sample[11:4], 4'h0} : sample;
            end else if (trig) begin
                m_left  = baddr ? CS : CF;
                m_short = baddr;
            end
            p_en = en; p_seln = sel_n; p_rdc = rdc;
        end
    end

    // Compare with the model at every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit m_busy, m_oe;
            logic [11:0] m_data;
            m_busy = (m_left > 0);
            m_oe   = en && !sel_n && rdc && !m_busy;
            if (!m_oe)      m_data = 12'h000;
            else if (wide)  m_data = m_res;
            else if (baddr) m_data = {m_res[3:0], 4'h0, 4'h0};
            else            m_data = {m_res[11:4], 4'h0};
            check("R4 busy", {11'b0, busy}, {11'b0, m_busy});
            check("R6 oe", {11'b0, oe}, {11'b0, m_oe});
            check(wide ? "R7 data" : "R8 data", data, m_data);
        end
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic drive(input logic e, input logic s, input logic r,
                         input logic w, input logic b);
        @(negedge clk); #1;
        en = e; sel_n = s; rdc = r; wide = w; baddr = b;
    endtask

    // Count the busy clocks at falling edges until busy drops
    task automatic measure(output int n);
        n = 0;
        @(negedge clk);
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 busy", {11'b0, busy}, 12'h000);
        drive(1, 0, 1, 1, 0);
        @(negedge clk);
        check("R10 result", data, 12'h000);
        #1 rst_n = 1'b1;
        drive(1, 0, 1, 1, 0);
        @(negedge clk);
        check("R10 result after release", data, 12'h000);

        // R1 start by convert falling, full length (R3)
        sample = 12'hA5C;
        drive(1, 0, 0, 1, 0);
        measure(n);
        check("R3 full length", 12'(n), 12'(CF));
        drive(1, 0, 1, 1, 0);
        @(negedge clk);
        check("R7 wide read", data, 12'hA5C);
        drive(1, 0, 1, 0, 0);
        @(negedge clk);
        check("R8 high byte", data, 12'hA50);
        drive(1, 0, 1, 0, 1);
        @(negedge clk);
        check("R8 low byte", data, 12'hC00);

        // R1 start by enable rising, short length; R9 truncation
        sample = 12'h3E7;
        drive(0, 0, 0, 1, 1);
        drive(1, 0, 0, 1, 1);
        measure(n);
        check("R3 short length", 12'(n), 12'(CS));
        // R2 condition still held: no restart
        repeat (4) @(negedge clk);
        check("R2 no restart", {11'b0, busy}, 12'h000);
        drive(1, 0, 1, 1, 0);
        @(negedge clk);
        check("R9 short stored", data, 12'h3E0);

        // R1 start by select falling, full; R5 toggles during busy
        sample = 12'h6B1;
        drive(1, 1, 0, 1, 0);
        drive(1, 0, 0, 1, 0);
        n = 1;
        for (int i = 0; i < 3; i++) begin
            drive(1, 1, 0, 1, 1); n++;
            drive(1, 0, 0, 1, 1); n++;
        end
        drive(1, 0, 1, 1, 1); n++;
        @(negedge clk);
        check("R6 no drive while busy", {11'b0, oe}, 12'h000);
        while (busy) begin n++; @(negedge clk); end
        check("R5 length unchanged", 12'(n), 12'(CF + 1));
        check("R7 wide read 2", data, 12'h6B1);

        // R6 no read with enable low or select high
        drive(0, 0, 1, 1, 0);
        @(negedge clk);
        check("R6 enable low", {oe, data[10:0]}, 12'h000);
        drive(1, 1, 1, 1, 0);
        @(negedge clk);
        check("R6 select high", {oe, data[10:0]}, 12'h000);

        // Back-to-back short then full via convert pulses
        sample = 12'hFFF;
        drive(1, 0, 0, 0, 1);
        measure(n);
        check("R3 short length 2", 12'(n), 12'(CS));
        drive(1, 0, 1, 0, 1);
        @(negedge clk);
        check("R8 low byte after short", data, 12'h000);
        drive(1, 0, 0, 0, 0);
        measure(n);
        check("R3 full length 2", 12'(n), 12'(CF));
        drive(1, 0, 1, 0, 1);
        @(negedge clk);
        check("R8 low byte after full", data, 12'hF00);

        // R10 reset mid-conversion
        drive(1, 0, 0, 1, 0);
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b0;
        @(negedge clk);
        check("R10 busy cleared", {11'b0, busy}, 12'h000);
        #1 rst_n = 1'b1;
        drive(1, 0, 1, 1, 0);
        @(negedge clk);
        check("R10 result cleared", data, 12'h000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule